// File: doc/BRIEF.md
# Flag-Offset Register Loader

This block holds the two threshold offsets used by a FIFO's almost-empty and almost-full flag comparators. Each offset is split over a low-byte register and a high-byte register, so there are four byte-wide offset registers in all. Software loads them through the FIFO's own data input while a load strobe is held low, and reads them back through the FIFO's data output. No address is given: one rotating pointer chooses the register for writes and another chooses it for reads. Both pointers step through the same fixed cycle of four registers.

The pointers keep their position when the load strobe goes high. A load can therefore be split over several sessions, and each new session starts at the register after the last one written. The load strobe pin has a second job, chosen at reset. If it is held low while reset is applied, the FIFO uses programmable flags and the load path is enabled. If it is held high, the pin acts as a plain second write enable and the offset registers keep their defaults. The two offsets are also presented as 16-bit words for the flag comparators. The FIFO storage and the comparators are outside this block.

Top module: `flo_offset_loader`

## Requirements
- R1: In every cycle in which `rst_n` is low, on the next clock edge the block sets both pointers to slot 0, sets `dout` to 0, and sets both `empty_offset` and `full_offset` to 7 (high byte 0, low byte 7).
- R2: A register write happens on a rising edge when four conditions hold: programmable mode is selected, `ld_n` is low, `wr_en_n` is low, and no read is requested. The write stores `din` into the slot at the write pointer. The slots come in the order 0 = empty-offset low byte, 1 = empty-offset high byte, 2 = full-offset low byte, 3 = full-offset high byte. Each write moves the write pointer on by one.
- R3: A write to slot 3 wraps the write pointer back to slot 0.
- R4: Cycles with `ld_n` high change no offset register and move neither pointer. The next load session therefore starts at the slot after the last one written.
- R5: A register read happens on a rising edge when four conditions hold: programmable mode is selected, `ld_n` is low, both `rd_en1_n` and `rd_en2_n` are low, and no write is requested. After that edge, `dout` shows the slot at the read pointer zero-extended. The read pointer then steps through the slot order of R2 and wraps after slot 3, independently of the write pointer. A read changes no offset register.
- R6: If a write and a read are both requested in the same cycle, neither happens: no register, pointer or `dout` changes.
- R7: The high-byte slots keep only the lowest ADDR_W-8 bits of `din` (2 bits by default). The other bits are read back as 0, both on `dout` and in bits 15:8 of the offset words.
- R8: If `ld_n` is high during reset, no later write or read request changes the offset registers or `dout`.
- R9: `dout` holds its value in every cycle that has no read, including cycles with only one read enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the load and the read paths |
| rst_n | input | 1 | Synchronous active-low reset; `ld_n` is sampled while it is low |
| ld_n | input | 1 | Active-low load strobe; its level during reset selects the mode |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en1_n | input | 1 | First active-low read enable |
| rd_en2_n | input | 1 | Second active-low read enable |
| din | input | 8 | Low byte of the FIFO data input, the value to load |
| dout | output | DATA_W (9) | Offset readback, zero-extended, held between reads |
| empty_offset | output | 16 | Empty offset as {slot 1, slot 0} |
| full_offset | output | 16 | Full offset as {slot 3, slot 2} |

## Verification
The assertions assume that `ld_n` is held at a steady level for at least one clock edge while `rst_n` is low. They also assume that the enables are not asserted during reset, so the sampled mode and the first post-reset values are well defined. The stimulus meets both assumptions: it parks `wr_en_n` and both read enables high, and drives `ld_n` to its chosen mode level before and throughout each reset. Outside reset, the random phase deliberately requests a write and a read together, so that the rule that neither takes effect is exercised as a legal input rather than excluded.

// File: rtl/flo_pkg.sv
// Package: shared constants and the slot type for the flag-offset loader.
// Assumes four byte-wide offset registers visited in a fixed cyclic order.
package flo_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam logic [BYTE_W-1:0] LO_DEFAULT = 8'd7;
    localparam logic [BYTE_W-1:0] HI_DEFAULT = 8'd0;

    // Slot order is behavioural: the pointers rely on it.
    typedef enum logic [SLOT_W-1:0] {
        SLOT_EMPTY_LO = 2'd0,
        SLOT_EMPTY_HI = 2'd1,
        SLOT_FULL_LO  = 2'd2,
        SLOT_FULL_HI  = 2'd3
    } slot_t;

    // High-byte slots have odd indices.
    function automatic logic is_hi_slot(input slot_t s);
        return s[0];
    endfunction
endpackage

// File: rtl/flo_ring_ptr.sv
// Module: rotating slot pointer. Steps through the four slots in order and
// wraps after the last. Assumes adv is pulsed at most once per cycle.
module flo_ring_ptr
    import flo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output slot_t idx
);
    localparam slot_t LAST = slot_t'(NUM_SLOTS - 1);

    // Pointer register: back to slot 0 on reset, one step per advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= SLOT_EMPTY_LO;
        else if (adv)
            idx <= (idx == LAST) ? SLOT_EMPTY_LO : slot_t'(idx + 1'b1);
    end
endmodule

// File: rtl/flo_ctrl.sv
// Module: mode capture and access decode. The load strobe level during reset
// selects programmable mode. Simultaneous write and read requests cancel.
// Assumes no enables are active while reset is applied.
module flo_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_n,
    input  logic wr_en_n,
    input  logic rd_en1_n,
    input  logic rd_en2_n,
    output logic prog_mode,
    output logic wr_go,
    output logic rd_go
);
    logic wr_req;
    logic rd_req;

    // Mode register: samples the strobe while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_mode <= ~ld_n;
    end

    // Request decode with mutual cancellation.
    always_comb begin
        wr_req = prog_mode && !ld_n && !wr_en_n;
        rd_req = prog_mode && !ld_n && !rd_en1_n && !rd_en2_n;
        wr_go  = wr_req && !rd_req;
        rd_go  = rd_req && !wr_req;
    end
endmodule

// File: rtl/flo_bank.sv
// Module: four offset registers with per-slot width masking and a registered
// readback byte. Assumes wr_go and rd_go are never high together.
module flo_bank
    import flo_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  slot_t             wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_go,
    input  slot_t             rd_idx,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] slot_q [NUM_SLOTS]
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [BYTE_W-1:0] HI_MASK = BYTE_W'((1 << HI_W) - 1);
    localparam logic [BYTE_W-1:0] LO_MASK = {BYTE_W{1'b1}};

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic              IS_HI = is_hi_slot(slot_t'(g));
        localparam logic [BYTE_W-1:0] MASK  = IS_HI ? HI_MASK : LO_MASK;
        localparam logic [BYTE_W-1:0] INIT  = IS_HI ? HI_DEFAULT : LO_DEFAULT;

        // Slot register: default on reset, masked load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= INIT;
            else if (wr_go && wr_idx == slot_t'(g))
                slot_q[g] <= wr_data & MASK;
        end
    end

    // Readback register: cleared on reset, updated only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_byte <= '0;
        else if (rd_go)
            rd_byte <= slot_q[rd_idx];
    end
endmodule

// File: rtl/flo_offset_loader.sv
// Module: top of the flag-offset loader. Ties the mode/decode logic, two
// rotating pointers and the register bank together, and assembles the 16-bit
// offsets. Assumes DATA_W > 8 and 8 < ADDR_W <= 16.
module flo_offset_loader
    import flo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_n,
    input  logic                wr_en_n,
    input  logic                rd_en1_n,
    input  logic                rd_en2_n,
    input  logic [BYTE_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic [2*BYTE_W-1:0] empty_offset,
    output logic [2*BYTE_W-1:0] full_offset
);
    localparam int PAD_W = DATA_W - BYTE_W;

    logic              prog_mode;
    logic              wr_go;
    logic              rd_go;
    slot_t             wr_idx;
    slot_t             rd_idx;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] slot_q [NUM_SLOTS];

    flo_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_n     (ld_n),
        .wr_en_n  (wr_en_n),
        .rd_en1_n (rd_en1_n),
        .rd_en2_n (rd_en2_n),
        .prog_mode(prog_mode),
        .wr_go    (wr_go),
        .rd_go    (rd_go)
    );

    flo_ring_ptr i_wr_ptr (.clk(clk), .rst_n(rst_n), .adv(wr_go), .idx(wr_idx));
    flo_ring_ptr i_rd_ptr (.clk(clk), .rst_n(rst_n), .adv(rd_go), .idx(rd_idx));

    flo_bank #(.ADDR_W(ADDR_W)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_go),
        .wr_idx (wr_idx),
        .wr_data(din),
        .rd_go  (rd_go),
        .rd_idx (rd_idx),
        .rd_byte(rd_byte),
        .slot_q (slot_q)
    );

    // Output assembly: zero-extend readback, pair the bytes into offsets.
    always_comb begin
        dout         = {{PAD_W{1'b0}}, rd_byte};
        empty_offset = {slot_q[SLOT_EMPTY_HI], slot_q[SLOT_EMPTY_LO]};
        full_offset  = {slot_q[SLOT_FULL_HI],  slot_q[SLOT_FULL_LO]};
    end
endmodule

// File: rtl/flo_checker.sv
// Module: property checker for the flag-offset loader, bound to the top.
// Assumes ld_n is steady through reset and enables are idle during reset.
module flo_checker #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              wr_en_n,
    input logic              rd_en1_n,
    input logic              rd_en2_n,
    input logic [DATA_W-1:0] dout,
    input logic [15:0]       empty_offset,
    input logic [15:0]       full_offset,
    input logic              prog_mode
);
    logic wr_req, rd_req;
    assign wr_req = !ld_n && !wr_en_n;
    assign rd_req = !ld_n && !rd_en1_n && !rd_en2_n;

    // R4: strobe high leaves all offsets and readback untouched.
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> ($stable(empty_offset) && $stable(full_offset) && $stable(dout)));

    // R6: conflicting requests change nothing.
    assert_conflict_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req) |=> ($stable(empty_offset) && $stable(full_offset) && $stable(dout)));

    // R5: a read leaves the offset registers alone.
    assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_req) |=> ($stable(empty_offset) && $stable(full_offset)));

    // R2: a write changes at most one byte.
    assert_write_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req) |=> ($countones({empty_offset[7:0]  != $past(empty_offset[7:0]),
                                              empty_offset[15:8] != $past(empty_offset[15:8]),
                                              full_offset[7:0]   != $past(full_offset[7:0]),
                                              full_offset[15:8]  != $past(full_offset[15:8])}) <= 1));

    // R8: outside programmable mode nothing changes.
    assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |=> ($stable(empty_offset) && $stable(full_offset) && $stable(dout)));

    // R9: no read means readback holds.
    assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && !wr_req) |=> $stable(dout));
endmodule

bind flo_offset_loader flo_checker #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_n        (ld_n),
    .wr_en_n     (wr_en_n),
    .rd_en1_n    (rd_en1_n),
    .rd_en2_n    (rd_en2_n),
    .dout        (dout),
    .empty_offset(empty_offset),
    .full_offset (full_offset),
    .prog_mode   (prog_mode)
);

// File: tb/test_flo_offset_loader.sv
module test_flo_offset_loader;
    localparam int DATA_W = 9;
    localparam int ADDR_W = 10;
    localparam logic [7:0] HMASK = 8'((1 << (ADDR_W - 8)) - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0, ld_n = 1'b0, wr_en_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic [7:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic [15:0] empty_offset, full_offset;

    int total = 0, bad = 0;
    bit done = 0;

    // bench model
    logic       m_mode;
    int         m_wp, m_rp;
    logic [7:0] m_reg [4];
    logic [7:0] m_dout;

    always #2 clk = ~clk;

    flo_offset_loader #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_flo_offset_loader (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en_n(wr_en_n),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .din(din), .dout(dout),
        .empty_offset(empty_offset), .full_offset(full_offset));

    function automatic logic [7:0] slot_mask(input int s);
        return (s % 2 == 1) ? HMASK : 8'hFF;
    endfunction

    function automatic logic [DATA_W+31:0] expected();
        return {{(DATA_W-8){1'b0}}, m_dout, m_reg[1], m_reg[0], m_reg[3], m_reg[2]};
    endfunction

    task automatic cycle(input logic rst, input logic ld, input logic we,
                         input logic r1, input logic r2, input logic [7:0] d,
                         input string tag);
        logic wreq, rreq;
        rst_n = rst; ld_n = ld; wr_en_n = we; rd_en1_n = r1; rd_en2_n = r2; din = d;
        @(posedge clk);
        if (!rst) begin
            m_mode = ~ld; m_wp = 0; m_rp = 0; m_dout = '0;
            m_reg[0] = 8'd7; m_reg[1] = 8'd0; m_reg[2] = 8'd7; m_reg[3] = 8'd0;
        end else begin
            wreq = m_mode && !ld && !we;
            rreq = m_mode && !ld && !r1 && !r2;
            if (wreq && !rreq) begin
                m_reg[m_wp] = d & slot_mask(m_wp);
                m_wp = (m_wp + 1) % 4;
            end else if (rreq && !wreq) begin
                m_dout = m_reg[m_rp];
                m_rp = (m_rp + 1) % 4;
            end
        end
        @(negedge clk);
        total++;
        if ({dout, empty_offset, full_offset} !== expected()) begin
            bad++;
            $display("FAIL %s: got dout=%h empty=%h full=%h expected dout=%h empty=%h full=%h",
                     tag, dout, empty_offset, full_offset, expected() >> 32,
                     expected()[31:16], expected()[15:0]);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1 reset state, programmable mode
        cycle(0, 0, 1, 1, 1, 8'h00, "R1");
        cycle(0, 0, 1, 1, 1, 8'h00, "R1");
        // R2 session 1: two writes, R7 high-byte masking
        cycle(1, 0, 0, 1, 1, 8'h3A, "R2");
        cycle(1, 0, 0, 1, 1, 8'hFF, "R7");
        // R4 strobe high: normal write, no effect
        cycle(1, 1, 0, 1, 1, 8'h55, "R4");
        cycle(1, 1, 0, 0, 0, 8'h66, "R4");
        // session 2 resumes at slot 2, then R3 wrap
        cycle(1, 0, 0, 1, 1, 8'hC4, "R4");
        cycle(1, 0, 0, 1, 1, 8'hAE, "R7");
        cycle(1, 0, 0, 1, 1, 8'h91, "R3");
        // R9 one read enable only
        cycle(1, 0, 1, 0, 1, 8'h00, "R9");
        cycle(1, 0, 1, 1, 0, 8'h00, "R9");
        // R5 reads with wrap
        for (int i = 0; i < 5; i++) cycle(1, 0, 1, 0, 0, 8'h00, "R5");
        // R6 conflict
        cycle(1, 0, 0, 0, 0, 8'h12, "R6");
        cycle(1, 0, 1, 0, 0, 8'h00, "R6");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic ld, we, r1, r2;
            string tag;
            ld = ($urandom % 10) < 3;
            we = ($urandom % 2);
            r1 = ($urandom % 10) < 4;
            r2 = ($urandom % 10) < 4;
            if (ld) tag = "R4";
            else if (!we && !r1 && !r2) tag = "R6";
            else if (!we) tag = "R2";
            else if (!r1 && !r2) tag = "R5";
            else tag = "R9";
            cycle(1, ld, we, r1, r2, 8'($urandom), tag);
        end
        // R8: reset with strobe high, then requests do nothing
        cycle(0, 1, 1, 1, 1, 8'h00, "R1");
        cycle(0, 1, 1, 1, 1, 8'h00, "R1");
        for (int i = 0; i < 200; i++)
            cycle(1, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                  8'($urandom), "R8");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule